// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block turns each 16-bit processor address into a physical RAM address and decides, for reads in the lowest and highest 16 KB of the address space, whether the data comes from a ROM instead. The processor space is cut into four 16 KB windows. Main RAM supplies logical blocks 0 to 3, and one expansion bank, picked by a bank number, supplies logical blocks 4 to 7. A three-bit layout code picks which block appears in which window. The layout code and the bank number are loaded together by one function of an 8-bit control port.

The ROM enables for the bottom and top windows come in as levels from elsewhere and affect only reads. A write always lands in RAM at the block the current layout puts in that window. A second, independent address input serves the display fetch path and is always mapped straight onto main RAM, whatever the layout.

Top module: `banked_mem_mapper`

## Requirements
- R1: After a synchronous reset, the layout code and the bank number are both 0, so window w maps to main block w. Control writes made while reset is high are not taken.
- R2: A control write is taken only when ctl_data[7:6] is 2'b11. It loads the layout code from ctl_data[2:0] and the bank number from ctl_data[5:3], and the new mapping applies from the next clock cycle. Writes with any other value in bits 7:6 leave the mapping unchanged.
- R3: Layouts 0 to 3 place these blocks in windows 0,1,2,3: layout 0 gives 0,1,2,3; layout 1 gives 0,1,2,7; layout 2 gives 4,5,6,7; layout 3 gives 0,3,2,7.
- R4: Layouts 4 to 7 place block 4, 5, 6 or 7 (layout minus 0) in window 1, and blocks 0, 2 and 3 in windows 0, 2 and 3.
- R5: phys_addr is {physical block, cpu_addr[13:0]}. Logical blocks 0 to 3 are physical blocks 0 to 3. Logical block 4+k of resolved bank r is physical block 4 + 4*r + k.
- R6: The bank number is resolved modulo NBANKS. With one fitted bank, every bank number selects that bank.
- R7: With NBANKS = 0, every layout code behaves as layout 0.
- R8: rom_lo_sel is high exactly when cpu_rd is high, lo_rom_en is high and cpu_addr[15:14] is 0. ram_rd is then low.
- R9: rom_hi_sel is high exactly when cpu_rd is high, hi_rom_en is high and cpu_addr[15:14] is 3. ram_rd is then low.
- R10: When cpu_wr is high, ram_we is high, ram_rd and both ROM selects are low, and phys_addr follows the RAM mapping, whatever the ROM enables are.
- R11: vid_phys always equals vid_addr zero-extended, so it addresses main RAM only, for every layout and bank.
- R12: With neither cpu_rd nor cpu_wr high, ram_rd, ram_we and both ROM selects are low. A read outside a ROM-enabled window drives ram_rd high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control port write strobe |
| ctl_data | input | 8 | Control byte; bits 7:6 select the function |
| lo_rom_en | input | 1 | Read overlay enable for window 0 |
| hi_rom_en | input | 1 | Read overlay enable for window 3 |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor memory read |
| cpu_wr | input | 1 | Processor memory write |
| vid_addr | input | 16 | Display fetch address |
| phys_addr | output | blk_bits(NBANKS)+14 | Physical RAM address for the processor access |
| ram_rd | output | 1 | RAM read select |
| rom_lo_sel | output | 1 | Low ROM select |
| rom_hi_sel | output | 1 | High ROM select |
| ram_we | output | 1 | RAM write enable |
| vid_phys | output | blk_bits(NBANKS)+14 | Physical RAM address for the display fetch |

## Verification
The bench builds three copies side by side. The first has NBANKS = 8. Here every bank number is a distinct bank, so a full sweep of the 64 layout and bank pairs over all four windows tests the block table and the physical block arithmetic. The second has NBANKS = 1 and shows every bank number collapsing onto one bank. The third has NBANKS = 0 and shows every layout folding onto the identity mapping. On these, the ROM-enable, read, write and idle combinations are swept in every window.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int WIN_BITS = 14;
    localparam int NWIN     = 4;

    typedef logic [1:0] win_t;
    typedef logic [2:0] blk_t;

    typedef enum logic [1:0] {
        FN_PALIDX = 2'b00,
        FN_PALVAL = 2'b01,
        FN_DISP   = 2'b10,
        FN_RAMMAP = 2'b11
    } ctl_fn_e;

    typedef struct packed {
        logic [2:0] bank;
        logic [2:0] layout;
    } map_cfg_t;

    function automatic int blk_bits(input int nbanks);
        return $clog2(4 * (nbanks + 1));
    endfunction

    function automatic int phys_bits(input int nbanks);
        return blk_bits(nbanks) + WIN_BITS;
    endfunction

    function automatic int bank_bits(input int nbanks);
        return (nbanks > 1) ? $clog2(nbanks) : 1;
    endfunction

    // logical block seen in window w under a layout code
    function automatic blk_t layout_block(input logic [2:0] layout, input win_t w);
        blk_t r;
        case (layout)
            3'd0:    r = {1'b0, w};
            3'd1:    r = (w == 2'd3) ? 3'd7 : {1'b0, w};
            3'd2:    r = {1'b1, w};
            3'd3:    r = (w == 2'd1) ? 3'd3 : ((w == 2'd3) ? 3'd7 : {1'b0, w});
            default: r = (w == 2'd1) ? {1'b1, layout[1:0]} : {1'b0, w};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mm_cfg_reg.sv
module mm_cfg_reg
    import mm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_data,
    output map_cfg_t   cfg
);

    ctl_fn_e fn;
    logic    take;

    assign fn   = ctl_fn_e'(ctl_data[7:6]);
    assign take = ctl_we && (fn == FN_RAMMAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (take) begin
            cfg.layout <= ctl_data[2:0];
            cfg.bank   <= ctl_data[5:3];
        end
    end

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (cfg == '0)); // R1
    AST_OTHER_FN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_data[7:6] != 2'b11) |=> $stable(cfg)); // R2
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(cfg)); // R2

endmodule

// File: rtl/mm_window_map.sv
module mm_window_map
    import mm_pkg::*;
#(
    parameter bit SWAP_EN = 1'b1
) (
    input  logic [2:0] layout,
    input  win_t       win,
    output blk_t       blk
);

    blk_t per_win [NWIN];

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            if (SWAP_EN) begin : g_swap
                assign per_win[g] = layout_block(layout, win_t'(g));
            end else begin : g_flat
                assign per_win[g] = blk_t'(g);
            end
        end
    endgenerate

    assign blk = per_win[win];

endmodule

// File: rtl/mm_bank_resolve.sv
module mm_bank_resolve
    import mm_pkg::*;
#(
    parameter int NBANKS = 8,
    localparam int RBW   = bank_bits(NBANKS)
) (
    input  logic [2:0]     bank,
    output logic [RBW-1:0] rbank
);

    generate
        if (NBANKS <= 1) begin : g_single
            assign rbank = '0;
        end else if ((NBANKS & (NBANKS - 1)) == 0) begin : g_pow2
            assign rbank = RBW'(bank);
        end else begin : g_mod
            logic [2:0] rem;
            assign rem   = bank % 3'(NBANKS);
            assign rbank = RBW'(rem);
        end
    endgenerate

endmodule

// File: rtl/banked_mem_mapper.sv
module banked_mem_mapper
    import mm_pkg::*;
#(
    parameter int NBANKS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ctl_we,
    input  logic [7:0]                   ctl_data,
    input  logic                         lo_rom_en,
    input  logic                         hi_rom_en,
    input  logic [15:0]                  cpu_addr,
    input  logic                         cpu_rd,
    input  logic                         cpu_wr,
    input  logic [15:0]                  vid_addr,
    output logic [phys_bits(NBANKS)-1:0] phys_addr,
    output logic                         ram_rd,
    output logic                         rom_lo_sel,
    output logic                         rom_hi_sel,
    output logic                         ram_we,
    output logic [phys_bits(NBANKS)-1:0] vid_phys
);

    localparam int PBW = blk_bits(NBANKS);
    localparam int PAW = phys_bits(NBANKS);
    localparam int RBW = bank_bits(NBANKS);

    map_cfg_t       cfg;
    win_t           win;
    blk_t           lblk;
    logic [RBW-1:0] rbank;
    logic [PBW-1:0] pblk;
    logic           rom_hit;

    mm_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctl_we   (ctl_we),
        .ctl_data (ctl_data),
        .cfg      (cfg)
    );

    assign win = cpu_addr[15:14];

    mm_window_map #(.SWAP_EN(NBANKS > 0)) u_map (
        .layout (cfg.layout),
        .win    (win),
        .blk    (lblk)
    );

    mm_bank_resolve #(.NBANKS(NBANKS)) u_bank (
        .bank  (cfg.bank),
        .rbank (rbank)
    );

    always_comb begin
        if (!lblk[2]) begin
            pblk = PBW'(lblk);
        end else begin
            pblk = PBW'(4) + PBW'({rbank, 2'b00}) + PBW'(lblk[1:0]);
        end
    end

    assign phys_addr  = {pblk, cpu_addr[WIN_BITS-1:0]};
    assign rom_lo_sel = cpu_rd && lo_rom_en && (win == 2'd0);
    assign rom_hi_sel = cpu_rd && hi_rom_en && (win == 2'd3);
    assign rom_hit    = rom_lo_sel || rom_hi_sel;
    assign ram_rd     = cpu_rd && !rom_hit;
    assign ram_we     = cpu_wr;
    assign vid_phys   = PAW'(vid_addr);

    AST_WR_GOES_TO_RAM: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |-> (ram_we && !rom_lo_sel && !rom_hi_sel && !ram_rd)); // R10
    AST_ROM_RAM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ram_rd && (rom_lo_sel || rom_hi_sel))); // R8
    AST_HI_ROM_TOP_ONLY: assert property (@(posedge clk) disable iff (rst)
        rom_hi_sel |-> (cpu_addr[15:14] == 2'd3)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !cpu_wr) |-> !(ram_rd || ram_we || rom_lo_sel || rom_hi_sel)); // R12
    AST_VID_MAIN_RAM: assert property (@(posedge clk) disable iff (rst)
        vid_phys == PAW'(vid_addr)); // R11
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        phys_addr[13:0] == cpu_addr[13:0]); // R5

    generate
        if (NBANKS == 0) begin : g_no_bank_chk
            AST_NO_BANK_FLAT: assert property (@(posedge clk) disable iff (rst)
                phys_addr[15:14] == cpu_addr[15:14]); // R7
        end
    endgenerate

endmodule

// File: tb/banked_mem_mapper_tb_top.sv
module banked_mem_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_data = '0;
    logic        lo_rom_en = 1'b0;
    logic        hi_rom_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] vid_addr = '0;

    logic [19:0] pa8, va8;
    logic [16:0] pa1, va1;
    logic [15:0] pa0, va0;
    logic        rr8, rl8, rh8, we8;
    logic        rr1, rl1, rh1, we1;
    logic        rr0, rl0, rh0, we0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    banked_mem_mapper #(.NBANKS(8)) dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .lo_rom_en(lo_rom_en), .hi_rom_en(hi_rom_en), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .vid_addr(vid_addr),
        .phys_addr(pa8), .ram_rd(rr8), .rom_lo_sel(rl8), .rom_hi_sel(rh8),
        .ram_we(we8), .vid_phys(va8));

    banked_mem_mapper #(.NBANKS(1)) dut_one (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .lo_rom_en(lo_rom_en), .hi_rom_en(hi_rom_en), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .vid_addr(vid_addr),
        .phys_addr(pa1), .ram_rd(rr1), .rom_lo_sel(rl1), .rom_hi_sel(rh1),
        .ram_we(we1), .vid_phys(va1));

    banked_mem_mapper #(.NBANKS(0)) dut_none (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .lo_rom_en(lo_rom_en), .hi_rom_en(hi_rom_en), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .vid_addr(vid_addr),
        .phys_addr(pa0), .ram_rd(rr0), .rom_lo_sel(rl0), .rom_hi_sel(rh0),
        .ram_we(we0), .vid_phys(va0));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk);
        ctl_we   = 1'b1;
        ctl_data = d;
        @(negedge clk);
        ctl_we   = 1'b0;
    endtask

    // logical block per layout and window, from the requirement tables
    function automatic int lblock(input int c, input int w);
        int t [4][4] = '{'{0,1,2,3}, '{0,1,2,7}, '{4,5,6,7}, '{0,3,2,7}};
        if (c < 4) return t[c][w];
        return (w == 1) ? c : w;
    endfunction

    function automatic int pblock(input int nb, input int c, input int b, input int w);
        int lb;
        int r;
        lb = (nb == 0) ? w : lblock(c, w);
        r  = (nb == 0) ? 0 : b % nb;
        return (lb < 4) ? lb : 4 + 4 * r + (lb - 4);
    endfunction

    function automatic logic [15:0] addr_of(input int w, input int salt);
        return {2'(w), 14'((salt * 733 + 5) & 16'h3FFF)};
    endfunction

    task automatic chk_map(input int c, input int b, input int w, input string tag8);
        int off;
        off = int'(cpu_addr[13:0]);
        chk(tag8,    32'(pa8), 32'(pblock(8, c, b, w) * 16384 + off));
        chk("R6",    32'(pa1), 32'(pblock(1, c, b, w) * 16384 + off));
        chk("R7",    32'(pa0), 32'(pblock(0, c, b, w) * 16384 + off));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        // R1: control write during reset must not be taken
        ctl_we   = 1'b1;
        ctl_data = 8'hFA;
        repeat (3) @(negedge clk);
        ctl_we = 1'b0;
        rst    = 1'b0;
        @(negedge clk);
        cpu_rd = 1'b1;
        for (int w = 0; w < 4; w++) begin
            cpu_addr = addr_of(w, w);
            #1;
            chk_map(0, 0, w, "R1");
        end

        // R2: other function codes ignored, from reset state
        wr_ctl(8'h3F);
        wr_ctl(8'h7E);
        wr_ctl(8'hBD);
        cpu_addr = addr_of(3, 9);
        #1;
        chk_map(0, 0, 3, "R2");

        // R3 R4 R5 R6 R7: full layout and bank sweep
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 8; b++) begin
                wr_ctl({2'b11, 3'(b), 3'(c)});
                for (int w = 0; w < 4; w++) begin
                    cpu_addr = addr_of(w, c * 32 + b * 4 + w);
                    #1;
                    chk_map(c, b, w, (c < 4) ? "R3+R5" : "R4+R5");
                end
            end
        end

        // R2: after a non-zero mapping, other functions keep it
        wr_ctl({2'b11, 3'd2, 3'd3});
        wr_ctl(8'h3F);
        wr_ctl(8'h47);
        wr_ctl(8'h80);
        for (int w = 0; w < 4; w++) begin
            cpu_addr = addr_of(w, 40 + w);
            #1;
            chk_map(3, 2, w, "R2");
        end

        // R8 R9 R10 R12: access kind x ROM enables x window, under layout 1 bank 6
        wr_ctl({2'b11, 3'd6, 3'd1});
        for (int op = 0; op < 3; op++) begin
            for (int le = 0; le < 2; le++) begin
                for (int he = 0; he < 2; he++) begin
                    for (int w = 0; w < 4; w++) begin
                        logic e_lo, e_hi, e_rd, e_we;
                        cpu_rd    = (op == 1);
                        cpu_wr    = (op == 2);
                        lo_rom_en = le[0];
                        hi_rom_en = he[0];
                        cpu_addr  = addr_of(w, op * 16 + le * 8 + he * 4 + w);
                        e_lo = (op == 1) && le[0] && (w == 0);
                        e_hi = (op == 1) && he[0] && (w == 3);
                        e_rd = (op == 1) && !e_lo && !e_hi;
                        e_we = (op == 2);
                        #1;
                        chk("R8",  32'({rl8, rl1, rl0}), 32'({3{e_lo}}));
                        chk("R9",  32'({rh8, rh1, rh0}), 32'({3{e_hi}}));
                        chk((op == 0) ? "R12" : "R8/R9", 32'({rr8, rr1, rr0}), 32'({3{e_rd}}));
                        chk((op == 2) ? "R10" : "R12", 32'({we8, we1, we0}), 32'({3{e_we}}));
                        if (op == 2) chk_map(1, 6, w, "R10");
                    end
                end
            end
        end
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;

        // R11: display path ignores layout and bank
        for (int c = 0; c < 8; c++) begin
            wr_ctl({2'b11, 3'(7 - c), 3'(c)});
            for (int k = 0; k < 4; k++) begin
                vid_addr = {2'(k), 14'((c * 977 + k * 311) & 16'h3FFF)};
                #1;
                chk("R11", 32'(va8), 32'(vid_addr));
                chk("R11", 32'(va1), 32'(vid_addr));
                chk("R11", 32'(va0), 32'(vid_addr));
            end
        end

        // R1: reset again returns to identity
        wr_ctl({2'b11, 3'd5, 3'd2});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cpu_rd = 1'b1;
        for (int w = 0; w < 4; w++) begin
            cpu_addr = addr_of(w, 90 + w);
            #1;
            chk_map(0, 0, w, "R1");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule